// File: doc/BRIEF.md
# Repeat-Block DMA Channel with Signed Source Stride

A single data-moving channel that copies words from a source address to a destination address over a simple valid/ready memory port. Each transfer is one read and then one write. The source and destination address units each step in one of three ways: hold, advance by the transfer size, or add a programmed signed stride. All address arithmetic wraps at the address width.

Transfers are grouped into repeat blocks of a programmed length. One of the two addresses is chosen as the repeat area. When a block completes, the channel does three things: it returns the repeat-area address to the value software last wrote into it, it clears its own enable bit, and it can latch an interrupt. Software then acknowledges the interrupt, may load a new source start address, and re-enables the channel. The destination address keeps its running value across the pause. With a column stride equal to the row pitch, and the source restarted one element further on after each block, successive blocks write a row-major matrix out as its transpose.

Top module: `rdma_chan`

## Requirements
- R1: After reset the enable bit and the interrupt are clear. No memory request is issued until software sets enable.
- R2: Every transfer is a read at the source address followed by a write of the returned data to the destination address. A request holds its valid, address and direction stable until ready is seen.
- R3: No transfer starts while enable (CTRL bit 0, register 5) is clear. A clear written during a transfer lets that transfer, and at most one already committed transfer, complete.
- R4: Source stepping is chosen by MODE bits [1:0]. 0 holds the address, 1 adds the transfer size in bytes, and 2 adds the signed stride register (register 2). The sum wraps modulo 2^ADDR_W.
- R5: Destination stepping is chosen by MODE bits [3:2], with the same encoding as R4.
- R6: MODE bits [5:4] select the transfer size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes. The size is driven on the memory port and sets the increment step.
- R7: A block ends after RPT transfers (register 3). A value of 0 acts as 1. The next block counts from zero again.
- R8: At block end the repeat-area address returns to the last value software wrote to its register. MODE bit 6 = 1 selects the source as the repeat area and 0 selects the destination. The other address keeps its running value.
- R9: Block end clears enable. Writing 1 to enable resumes from the preserved addresses.
- R10: If MODE bit 7 is set, block end sets the interrupt. The interrupt stays high until a write of 1 to STAT bit 0 (register 6). With MODE bit 7 clear, no interrupt is raised.
- R11: With a stride of 16, a repeat size of 4, word size, an incrementing destination, and the source restarted at the block start plus 4 after each block, four blocks transpose a 4x4 word matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index: 0 SRC, 1 DST, 2 stride, 3 RPT, 4 MODE, 5 CTRL, 6 STAT |
| reg_wdata_i | input | ADDR_W | Register write data |
| reg_rdata_o | output | ADDR_W | Read data for reg_addr_i; SRC and DST return the live addresses |
| irq_o | output | 1 | Block-end interrupt |
| mem_valid_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 for write, 0 for read |
| mem_addr_o | output | ADDR_W | Byte address |
| mem_size_o | output | 2 | Transfer size code |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Request accepted |

## Verification
The bench builds the channel with a 16-bit address, a 32-bit data path and a 4-bit repeat counter. The 16-bit address lets a negative stride carry the source from 0x0004 down past zero to 0xFFFC, which checks that the sum wraps. The memory model stalls ready one cycle in four, so requests that are held under back-pressure occur in every scenario. The small counter keeps every block short, so the transpose, the destination repeat area, the zero repeat size and a software stop partway through a block all finish in a few hundred cycles.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
  typedef enum logic [1:0] {AM_FIXED = 2'd0, AM_INC = 2'd1, AM_OFS = 2'd2} amode_e;

  typedef enum logic [2:0] {
    RA_SRC = 3'd0, RA_DST = 3'd1, RA_OFS = 3'd2, RA_RPT = 3'd3,
    RA_MODE = 3'd4, RA_CTRL = 3'd5, RA_STAT = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic       irq_en;
    logic       area_src;
    logic [1:0] size;
    logic [1:0] dst_mode;
    logic [1:0] src_mode;
  } mode_t;

  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xstate_e;

  function automatic logic [2:0] size_bytes(logic [1:0] s);
    case (s)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rdma_addr_gen.sv
module rdma_addr_gen
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        load_val_i,
  input  logic                     step_i,
  input  logic                     restore_i,
  input  logic [1:0]               mode_i,
  input  logic [1:0]               size_i,
  input  logic signed [ADDR_W-1:0] ofs_i,
  output logic [ADDR_W-1:0]        addr_o
);
  logic [ADDR_W-1:0] addr_q, start_q, step_amt;

  always_comb begin
    case (amode_e'(mode_i))
      AM_INC:  step_amt = ADDR_W'(size_bytes(size_i));
      AM_OFS:  step_amt = ofs_i;
      default: step_amt = '0;
    endcase
  end

  // software load beats block restore, which beats the running step
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      start_q <= '0;
    end else if (load_i) begin
      addr_q  <= load_val_i;
      start_q <= load_val_i;
    end else if (restore_i) begin
      addr_q  <= start_q;
    end else if (step_i) begin
      addr_q  <= addr_q + step_amt;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/rdma_xfer_fsm.sv
module rdma_xfer_fsm
  import rdma_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [CNT_W-1:0]  rpt_i,
  input  logic              cnt_clr_i,
  input  logic              mem_ready_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              rd_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              step_o,
  output logic              blk_end_o
);
  xstate_e           state_q;
  logic [CNT_W-1:0]  cnt_q, rpt_eff;
  logic [DATA_W-1:0] data_q;
  logic              last;

  assign rpt_eff   = (rpt_i == '0) ? CNT_W'(1) : rpt_i;
  assign last      = ({1'b0, cnt_q} + 1'b1) >= {1'b0, rpt_eff};
  assign rd_o      = (state_q == XS_RD);
  assign wr_o      = (state_q == XS_WR);
  assign step_o    = wr_o && mem_ready_i;
  assign blk_end_o = step_o && last;
  assign data_o    = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      data_q  <= '0;
    end else begin
      case (state_q)
        XS_IDLE: if (en_i) state_q <= XS_RD;
        XS_RD: if (mem_ready_i) begin
          data_q  <= mem_rdata_i;
          state_q <= XS_WR;
        end
        XS_WR: if (mem_ready_i) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (cnt_clr_i) cnt_q <= '0;
    else if (blk_end_o) cnt_q <= '0;
    else if (step_o)    cnt_q <= cnt_q + 1'b1;
  end

  a_r2_rd_before_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_o) |-> $past(rd_o && mem_ready_i));
  a_r7_cnt_in_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < rpt_eff);
endmodule

// File: rtl/rdma_regs.sv
module rdma_regs
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     reg_we_i,
  input  logic [2:0]               reg_addr_i,
  input  logic [ADDR_W-1:0]        reg_wdata_i,
  input  logic                     blk_end_i,
  input  logic [ADDR_W-1:0]        src_addr_i,
  input  logic [ADDR_W-1:0]        dst_addr_i,
  output logic                     src_wr_o,
  output logic                     dst_wr_o,
  output logic                     rpt_wr_o,
  output logic signed [ADDR_W-1:0] ofs_o,
  output logic [CNT_W-1:0]         rpt_o,
  output mode_t                    mode_o,
  output logic                     en_o,
  output logic                     irq_o,
  output logic [ADDR_W-1:0]        reg_rdata_o
);
  logic [ADDR_W-1:0] ofs_q;
  logic [CNT_W-1:0]  rpt_q;
  mode_t             mode_q;
  logic              en_q, irq_q;
  logic              ofs_wr, mode_wr, ctrl_wr, stat_wr;

  assign src_wr_o = reg_we_i && (reg_addr_i == RA_SRC);
  assign dst_wr_o = reg_we_i && (reg_addr_i == RA_DST);
  assign rpt_wr_o = reg_we_i && (reg_addr_i == RA_RPT);
  assign ofs_wr   = reg_we_i && (reg_addr_i == RA_OFS);
  assign mode_wr  = reg_we_i && (reg_addr_i == RA_MODE);
  assign ctrl_wr  = reg_we_i && (reg_addr_i == RA_CTRL);
  assign stat_wr  = reg_we_i && (reg_addr_i == RA_STAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      rpt_q  <= '0;
      mode_q <= '0;
    end else begin
      if (ofs_wr)   ofs_q  <= reg_wdata_i;
      if (rpt_wr_o) rpt_q  <= reg_wdata_i[CNT_W-1:0];
      if (mode_wr)  mode_q <= mode_t'(reg_wdata_i[7:0]);
    end
  end

  // block end wins over a same-cycle software write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (blk_end_i)    en_q <= 1'b0;
      else if (ctrl_wr) en_q <= reg_wdata_i[0];
      if (blk_end_i && mode_q.irq_en)   irq_q <= 1'b1;
      else if (stat_wr && reg_wdata_i[0]) irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr_i)
      RA_SRC:  reg_rdata_o = src_addr_i;
      RA_DST:  reg_rdata_o = dst_addr_i;
      RA_OFS:  reg_rdata_o = ofs_q;
      RA_RPT:  reg_rdata_o = ADDR_W'(rpt_q);
      RA_MODE: reg_rdata_o = ADDR_W'(mode_q);
      RA_CTRL: reg_rdata_o = ADDR_W'(en_q);
      RA_STAT: reg_rdata_o = ADDR_W'(irq_q);
      default: reg_rdata_o = '0;
    endcase
  end

  assign ofs_o  = ofs_q;
  assign rpt_o  = rpt_q;
  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/rdma_chan.sv
module rdma_chan
  import rdma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  output logic [ADDR_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              mem_valid_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_ready_i
);
  logic                     src_wr, dst_wr, rpt_wr, en, step, blk_end, rd, wr;
  logic signed [ADDR_W-1:0] ofs;
  logic [CNT_W-1:0]         rpt;
  mode_t                    mode;
  logic [ADDR_W-1:0]        src_addr, dst_addr;

  rdma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
    .blk_end_i(blk_end), .src_addr_i(src_addr), .dst_addr_i(dst_addr),
    .src_wr_o(src_wr), .dst_wr_o(dst_wr), .rpt_wr_o(rpt_wr),
    .ofs_o(ofs), .rpt_o(rpt), .mode_o(mode), .en_o(en), .irq_o(irq_o),
    .reg_rdata_o(reg_rdata_o)
  );

  rdma_xfer_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
    .clk_i, .rst_ni, .en_i(en), .rpt_i(rpt), .cnt_clr_i(rpt_wr),
    .mem_ready_i, .mem_rdata_i, .rd_o(rd), .wr_o(wr), .data_o(mem_wdata_o),
    .step_o(step), .blk_end_o(blk_end)
  );

  rdma_addr_gen #(.ADDR_W(ADDR_W)) src_gen_i (
    .clk_i, .rst_ni, .load_i(src_wr), .load_val_i(reg_wdata_i), .step_i(step),
    .restore_i(blk_end && mode.area_src), .mode_i(mode.src_mode),
    .size_i(mode.size), .ofs_i(ofs), .addr_o(src_addr)
  );

  rdma_addr_gen #(.ADDR_W(ADDR_W)) dst_gen_i (
    .clk_i, .rst_ni, .load_i(dst_wr), .load_val_i(reg_wdata_i), .step_i(step),
    .restore_i(blk_end && !mode.area_src), .mode_i(mode.dst_mode),
    .size_i(mode.size), .ofs_i(ofs), .addr_o(dst_addr)
  );

  assign mem_valid_o = rd || wr;
  assign mem_we_o    = wr;
  assign mem_addr_o  = wr ? dst_addr : src_addr;
  assign mem_size_o  = mode.size;

  a_r2_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));
  a_r3_start_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_valid_o) |-> $past(en));
  a_r9_end_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end |=> !en);
  a_r10_irq_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(blk_end));
endmodule

// File: tb/rdma_chan_tb_top.sv
module rdma_chan_tb_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [AW-1:0] reg_wdata = '0;
  logic [AW-1:0] reg_rdata;
  logic          irq, mem_valid, mem_we, mem_ready = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_size;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #5 clk = ~clk;

  rdma_chan #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq),
    .mem_valid_o(mem_valid), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .mem_ready_i(mem_ready)
  );

  logic [7:0] mem [256];
  logic [7:0] ma;
  int rd_cnt = 0, wr_cnt = 0, seq_err = 0, checks = 0, fails = 0;
  int last_wr = 0;
  bit last_was_rd = 0, stalled = 0, done = 0;
  logic [AW-1:0] stall_addr;
  logic [DW-1:0] last_rdata;
  logic [1:0] cyc = '0;

  function automatic logic [7:0] pat(int i);
    return 8'(i * 7 + 3);
  endfunction

  function automatic logic [31:0] word_at(int a);
    return {mem[8'(a + 3)], mem[8'(a + 2)], mem[8'(a + 1)], mem[8'(a)]};
  endfunction

  assign ma = mem_addr[7:0];
  assign mem_rdata = {mem[8'(ma + 8'd3)], mem[8'(ma + 8'd2)], mem[8'(ma + 8'd1)], mem[ma]};

  always @(negedge clk) begin
    cyc <= cyc + 2'd1;
    mem_ready <= (cyc != 2'd3);
  end

  // memory model plus R2 sequencing and hold monitor
  always @(posedge clk) begin
    if (rst_n) begin
      if (stalled && (!mem_valid || mem_addr != stall_addr)) seq_err <= seq_err + 1;
      stalled <= mem_valid && !mem_ready;
      stall_addr <= mem_addr;
      if (mem_valid && mem_ready) begin
        if (mem_we) begin
          if (!last_was_rd || mem_wdata != last_rdata) seq_err <= seq_err + 1;
          mem[ma] <= mem_wdata[7:0];
          if (mem_size != 2'd0) mem[8'(ma + 8'd1)] <= mem_wdata[15:8];
          if (mem_size[1]) begin
            mem[8'(ma + 8'd2)] <= mem_wdata[23:16];
            mem[8'(ma + 8'd3)] <= mem_wdata[31:24];
          end
          wr_cnt <= wr_cnt + 1;
          last_wr <= int'(mem_addr);
          last_was_rd <= 1'b0;
        end else begin
          if (last_was_rd) seq_err <= seq_err + 1;
          rd_cnt <= rd_cnt + 1;
          last_rdata <= mem_rdata;
          last_was_rd <= 1'b1;
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, int d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = AW'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(logic [2:0] a, output int d);
    reg_addr = a;
    #1;
    d = int'(reg_rdata);
  endtask

  task automatic rd_chk(logic [2:0] a, int exp, string tag);
    int v;
    reg_rd(a, v);
    chk(v == exp, tag, v, exp);
  endtask

  task automatic wait_irq(string tag);
    int n = 0;
    while (!irq && n < 2000) begin @(negedge clk); n++; end
    chk(irq, tag, int'(irq), 1);
  endtask

  task automatic wait_stop(string tag);
    int v, n = 0;
    reg_rd(3'd5, v);
    while (v != 0 && n < 2000) begin @(negedge clk); reg_rd(3'd5, v); n++; end
    chk(v == 0, tag, v, 0);
  endtask

  task automatic t_reset();
    chk(!irq, "R1 irq after reset", int'(irq), 0);
    chk(!mem_valid, "R1 no request after reset", int'(mem_valid), 0);
    rd_chk(3'd5, 0, "R1 enable after reset");
    rd_chk(3'd6, 0, "R1 status after reset");
  endtask

  task automatic t_idle_disabled();
    reg_wr(3'd0, 'h40); reg_wr(3'd1, 'h80); reg_wr(3'd3, 2); reg_wr(3'd4, 'h65);
    repeat (40) @(negedge clk);
    chk(rd_cnt == 0 && wr_cnt == 0, "R3 no transfer while disabled", rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_xy();
    logic [31:0] snap [16];
    for (int i = 0; i < 16; i++) snap[i] = word_at('h40 + 4 * i);
    reg_wr(3'd0, 'h40); reg_wr(3'd1, 'h80); reg_wr(3'd2, 'h10);
    reg_wr(3'd3, 4); reg_wr(3'd4, 'hE6);
    for (int b = 0; b < 4; b++) begin
      int base = wr_cnt;
      reg_wr(3'd5, 1);
      wait_irq("R10 irq at block end");
      chk(wr_cnt - base == 4, "R7 block length", wr_cnt - base, 4);
      rd_chk(3'd0, 'h40 + 4 * b, "R8 source returned to block start");
      rd_chk(3'd1, 'h80 + 16 * (b + 1), "R5 destination keeps running value");
      rd_chk(3'd5, 0, "R9 enable cleared at block end");
      if (b == 0) begin
        repeat (20) @(negedge clk);
        chk(irq, "R10 irq held until ack", int'(irq), 1);
        chk(wr_cnt - base == 4, "R9 paused after block", wr_cnt - base, 4);
      end
      reg_wr(3'd6, 1);
      chk(!irq, "R10 irq cleared by ack", int'(irq), 0);
      if (b < 3) reg_wr(3'd0, 'h40 + 4 * (b + 1));
    end
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++) begin
        logic [31:0] got = word_at('h80 + 16 * c + 4 * r);
        chk(got == snap[4 * r + c], "R11 transposed element", int'(got), int'(snap[4 * r + c]));
      end
  endtask

  task automatic t_dst_area();
    int base;
    reg_wr(3'd0, 'h10); reg_wr(3'd1, 'hC0); reg_wr(3'd3, 3); reg_wr(3'd4, 'h85);
    reg_wr(3'd5, 1);
    wait_irq("R10 irq dst area");
    rd_chk(3'd1, 'hC0, "R8 destination returned");
    rd_chk(3'd0, 'h13, "R4 R6 source byte increment");
    for (int i = 0; i < 3; i++)
      chk(mem['hC0 + i] == pat('h10 + i), "R6 byte copy", int'(mem['hC0 + i]), int'(pat('h10 + i)));
    chk(mem['hC3] == pat('hC3), "R6 byte size leaves neighbour", int'(mem['hC3]), int'(pat('hC3)));
    reg_wr(3'd6, 1);
    base = wr_cnt;
    reg_wr(3'd5, 1);
    wait_irq("R9 resume second block");
    chk(wr_cnt - base == 3, "R7 counter restarts", wr_cnt - base, 3);
    chk(mem['hC0] == pat('h13), "R9 resumed source preserved", int'(mem['hC0]), int'(pat('h13)));
    rd_chk(3'd0, 'h16, "R9 source continues");
    reg_wr(3'd6, 1);
  endtask

  task automatic t_neg_wrap();
    reg_wr(3'd0, 'h0004); reg_wr(3'd1, 'hD0); reg_wr(3'd2, 'hFFF8);
    reg_wr(3'd3, 2); reg_wr(3'd4, 'h56);
    reg_wr(3'd5, 1);
    wait_stop("R9 stop after wrap block");
    rd_chk(3'd0, 'h0004, "R8 source restored after wrap");
    rd_chk(3'd1, 'hD4, "R6 half-word destination step");
    chk({mem['hD1], mem['hD0]} == {pat(5), pat(4)}, "R4 first half word",
        int'({mem['hD1], mem['hD0]}), int'({pat(5), pat(4)}));
    chk({mem['hD3], mem['hD2]} == {pat('hFD), pat('hFC)}, "R4 wrapped negative stride",
        int'({mem['hD3], mem['hD2]}), int'({pat('hFD), pat('hFC)}));
    chk(!irq, "R10 no irq when disabled", int'(irq), 0);
  endtask

  task automatic t_fixed_dstofs();
    logic [31:0] w = word_at('h20);
    reg_wr(3'd0, 'h20); reg_wr(3'd1, 'hE0); reg_wr(3'd2, 8);
    reg_wr(3'd3, 2); reg_wr(3'd4, 'h68);
    reg_wr(3'd5, 1);
    wait_stop("R9 stop fixed block");
    rd_chk(3'd0, 'h20, "R4 fixed source");
    rd_chk(3'd1, 'hF0, "R5 destination stride");
    chk(last_wr == 'hE8, "R5 second write address", last_wr, 'hE8);
    chk(word_at('hE0) == w && word_at('hE8) == w, "R4 fixed source data",
        int'(word_at('hE8)), int'(w));
  endtask

  task automatic t_rpt_zero();
    int base = wr_cnt;
    reg_wr(3'd0, 'h30); reg_wr(3'd1, 'hF0); reg_wr(3'd3, 0); reg_wr(3'd4, 'h65);
    reg_wr(3'd5, 1);
    wait_stop("R7 zero size stops");
    chk(wr_cnt - base == 1, "R7 zero size is one transfer", wr_cnt - base, 1);
    rd_chk(3'd0, 'h30, "R8 restore after single transfer");
    rd_chk(3'd1, 'hF4, "R6 word destination step");
  endtask

  task automatic t_sw_stop();
    int base = wr_cnt, n = 0;
    reg_wr(3'd0, 'h00); reg_wr(3'd1, 'h90); reg_wr(3'd3, 8); reg_wr(3'd4, 'hE5);
    reg_wr(3'd5, 1);
    while (wr_cnt - base < 1 && n < 2000) begin @(negedge clk); n++; end
    reg_wr(3'd5, 0);
    repeat (30) @(negedge clk);
    chk(wr_cnt - base == 2, "R3 stop after committed transfer", wr_cnt - base, 2);
    rd_chk(3'd0, 'h08, "R3 source not restored on stop");
    rd_chk(3'd1, 'h98, "R3 destination after stop");
    chk(!irq, "R3 no irq on software stop", int'(irq), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = pat(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_disabled();
    t_xy();
    t_dst_area();
    t_neg_wrap();
    t_fixed_dstofs();
    t_rpt_zero();
    t_sw_stop();
    chk(seq_err == 0, "R2 read-write order and hold", seq_err, 0);
    chk(rd_cnt == wr_cnt, "R2 one read per write", rd_cnt, wr_cnt);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R9 actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule